// File: doc/BRIEF.md
# Dual-channel IDE interrupt status mirror

This block is the interrupt-status slice of a disk controller's configuration space. Each of two disk channels raises a level-sensitive event. That event is latched as a status flag, and the flag can be read at two places in configuration space: a legacy per-channel byte and a combined status/block byte. Both views show the same state at all times. Software clears a flag by writing a one to it at either place, and the other view follows at once.

A per-channel block bit, loaded through a separate side write path, gates the flag before it reaches the single shared interrupt line. The line is high whenever at least one channel has its flag set and is not blocked. The slice also answers reads of a few identity bytes and of a channel-enable control byte.

The configuration port is a plain register port. A write is taken in the cycle that `cfg_wr` is high, and there is no back-pressure. Reads are combinational from `cfg_raddr`. The port is one dword wide, with per-byte enables. Every enabled byte is handled as its own byte write.

Top module: `ide_irq_mirror`

## Requirements
- R1: After reset both flags and both block bits are 0 and `irq_out` is 0. The control byte at offset 0x51 reads 0x04, plus bit 3 (0x08) when `SECONDARY_EN` is 1. With the default parameter it reads 0x0C.
- R2: Byte 0x09 reads 0x8F and byte 0x3D reads 0x01. Every other offset that this slice does not own reads 0.
- R3: The channel 0 flag reads at offset 0x50 bit 2 and at offset 0x71 bit 2. The channel 1 flag reads at offset 0x57 bit 4 and at offset 0x71 bit 3. The block bits read at offset 0x71 bits 4 (channel 0) and 5 (channel 1). The two places for a channel always agree.
- R4: A rising edge on `chan_irq[i]` sets flag i, and the flag is visible after the next clock edge.
- R5: A falling edge on `chan_irq[i]` clears flag i.
- R6: Writing a 1 to the legacy flag bit (0x50 bit 2 or 0x57 bit 4) clears that channel's flag in both views. Writing a 0 there leaves it unchanged.
- R7: Writing a 1 to offset 0x71 bit 2 or bit 3 clears the flag of channel 0 or channel 1 in both views.
- R8: No other bit of 0x50, 0x51, 0x57 or 0x71 can be changed by a configuration write. This includes the block bits.
- R9: A byte lane whose `cfg_be` bit is 0 has no effect. All enabled lanes of one dword write act together.
- R10: `blk_wr` loads the block bits from `blk_wdata` (bit 0 for channel 0, bit 1 for channel 1). A blocked channel cannot drive `irq_out`.
- R11: `irq_out` equals (flag0 AND NOT block0) OR (flag1 AND NOT block1), in the same cycle as the state.
- R12: A rising edge on a channel in the same cycle as a write that clears that channel leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_waddr | input | 6 | Write dword address (byte offset / 4) |
| cfg_be | input | 4 | Write byte enables, lane n = byte offset 4*addr+n |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_raddr | input | 6 | Read dword address |
| cfg_rdata | output | 32 | Read data for `cfg_raddr` |
| chan_irq | input | 2 | Per-channel interrupt level from the disk channels |
| blk_wr | input | 1 | Side write strobe for the block bits |
| blk_wdata | input | 2 | New block bits |
| irq_out | output | 1 | Level-sensitive interrupt line |

## Verification
A flag that is wrong inside the slice shows up in the very next read of either of its two byte places. If the channel is not blocked, it also shows up on `irq_out` in the same cycle. A set or clear that is lost, or that arrives a cycle late, therefore makes the per-cycle comparison against the bench's model differ one clock after the edge or write that caused it. A block bit that is wrong is seen at offset 0x71 and on `irq_out` while the matching flag is set.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int CFG_AW = 8;
  localparam int NCH    = 2;

  localparam logic [CFG_AW-1:0] OFF_PIF  = 8'h09;
  localparam logic [CFG_AW-1:0] OFF_IPIN = 8'h3D;
  localparam logic [CFG_AW-1:0] OFF_LEG0 = 8'h50;
  localparam logic [CFG_AW-1:0] OFF_CTRL = 8'h51;
  localparam logic [CFG_AW-1:0] OFF_LEG1 = 8'h57;
  localparam logic [CFG_AW-1:0] OFF_COMB = 8'h71;

  localparam logic [7:0] VAL_PIF  = 8'h8F;
  localparam logic [7:0] VAL_IPIN = 8'h01;

  localparam int LEG0_BIT      = 2;
  localparam int LEG1_BIT      = 4;
  localparam int COMB_FLAG_LSB = 2;
  localparam int COMB_MASK_LSB = 4;
  localparam int CTRL_EN_LSB   = 2;

  typedef logic [NCH-1:0] chvec_t;

  function automatic logic [CFG_AW-1:0] leg_off(input int ch);
    return (ch == 0) ? OFF_LEG0 : OFF_LEG1;
  endfunction

  function automatic int leg_bit(input int ch);
    return (ch == 0) ? LEG0_BIT : LEG1_BIT;
  endfunction
endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic flag
);
  logic lvl_q;
  logic rise, fall;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (rise)             flag <= 1'b1;
      else if (fall || clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ide_irq_wdec.sv
module ide_irq_wdec
  import ide_irq_pkg::*;
#(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int WA_W  = CFG_AW - LSB_W
) (
  input  logic             cfg_wr,
  input  logic [WA_W-1:0]  cfg_waddr,
  input  logic [LANES-1:0] cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  output chvec_t           clr
);
  always_comb begin
    clr = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [CFG_AW-1:0] off;
      logic [7:0]        b;
      off = {cfg_waddr, LSB_W'(l)};
      b   = cfg_wdata[8*l +: 8];
      if (cfg_wr && cfg_be[l]) begin
        for (int c = 0; c < NCH; c++) begin
          if (off == leg_off(c) && b[leg_bit(c)])      clr[c] = 1'b1;
          if (off == OFF_COMB && b[COMB_FLAG_LSB + c]) clr[c] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ide_irq_rmux.sv
module ide_irq_rmux
  import ide_irq_pkg::*;
#(
  parameter int DW = 32,
  parameter bit SECONDARY_EN = 1'b1,
  localparam int LANES = DW / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int WA_W  = CFG_AW - LSB_W
) (
  input  logic [WA_W-1:0] cfg_raddr,
  input  chvec_t          flag,
  input  chvec_t          mask,
  output logic [DW-1:0]   cfg_rdata
);
  localparam logic [7:0] CTRL_RST =
    (8'h01 << CTRL_EN_LSB) | (SECONDARY_EN ? (8'h02 << CTRL_EN_LSB) : 8'h00);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CFG_AW-1:0] off;
    assign off = {cfg_raddr, LSB_W'(l)};
    always_comb begin
      logic [7:0] b;
      b = 8'h00;
      unique case (off)
        OFF_PIF:  b = VAL_PIF;
        OFF_IPIN: b = VAL_IPIN;
        OFF_CTRL: b = CTRL_RST;
        OFF_LEG0: b[LEG0_BIT] = flag[0];
        OFF_LEG1: b[LEG1_BIT] = flag[1];
        OFF_COMB: begin
          b[COMB_FLAG_LSB +: NCH] = flag;
          b[COMB_MASK_LSB +: NCH] = mask;
        end
        default:  b = 8'h00;
      endcase
      cfg_rdata[8*l +: 8] = b;
    end
  end
endmodule

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror
  import ide_irq_pkg::*;
#(
  parameter int DW = 32,
  parameter bit SECONDARY_EN = 1'b1,
  localparam int LANES = DW / 8,
  localparam int LSB_W = $clog2(LANES),
  localparam int WA_W  = CFG_AW - LSB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [WA_W-1:0]  cfg_waddr,
  input  logic [LANES-1:0] cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [WA_W-1:0]  cfg_raddr,
  output logic [DW-1:0]    cfg_rdata,
  input  logic [NCH-1:0]   chan_irq,
  input  logic             blk_wr,
  input  logic [NCH-1:0]   blk_wdata,
  output logic             irq_out
);
  chvec_t chan_clr;
  chvec_t chan_flag;
  chvec_t blk_q;

  ide_irq_wdec #(.DW(DW)) u_wdec (
    .cfg_wr   (cfg_wr),
    .cfg_waddr(cfg_waddr),
    .cfg_be   (cfg_be),
    .cfg_wdata(cfg_wdata),
    .clr      (chan_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ide_irq_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (chan_irq[c]),
      .clr  (chan_clr[c]),
      .flag (chan_flag[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (blk_wr) blk_q <= blk_wdata;
  end

  ide_irq_rmux #(.DW(DW), .SECONDARY_EN(SECONDARY_EN)) u_rmux (
    .cfg_raddr(cfg_raddr),
    .flag     (chan_flag),
    .mask     (blk_q),
    .cfg_rdata(cfg_rdata)
  );

  assign irq_out = |(chan_flag & ~blk_q);
endmodule

// File: rtl/ide_irq_mirror_chk.sv
module ide_irq_mirror_chk
  import ide_irq_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input chvec_t chan_irq,
  input chvec_t flag,
  input chvec_t mask,
  input logic   irq_out
);
  chvec_t prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chan_irq;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4 R12
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_irq[c] && !prev_q[c]) |=> flag[c]);
    // R5
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_irq[c] && prev_q[c]) |=> !flag[c]);
    // R8
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[c] && !(chan_irq[c] && !prev_q[c])) |=> !flag[c]);
    // R11
    unblocked_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[c] && !mask[c]) |-> irq_out);
  end

  // R10
  all_blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq_out);
  // R11
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(flag & ~mask)));
endmodule

bind ide_irq_mirror ide_irq_mirror_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .chan_irq(chan_irq),
  .flag    (chan_flag),
  .mask    (blk_q),
  .irq_out (irq_out)
);

// File: tb/tb_ide_irq_mirror.sv
module tb_ide_irq_mirror;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_waddr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  chan_irq = '0;
  logic        blk_wr = 1'b0;
  logic [1:0]  blk_wdata = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ide_irq_mirror dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .chan_irq(chan_irq), .blk_wr(blk_wr),
    .blk_wdata(blk_wdata), .irq_out(irq_out)
  );

  // behavioural reference model
  bit mf[2], mm[2], mp[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin mf[c] = 0; mm[c] = 0; mp[c] = 0; end
    end else begin
      bit clr[2];
      clr[0] = 0; clr[1] = 0;
      if (cfg_wr) begin
        for (int l = 0; l < 4; l++) begin
          if (cfg_be[l]) begin
            int off;
            logic [7:0] b;
            off = cfg_waddr * 4 + l;
            b = cfg_wdata[8*l +: 8];
            if ((off == 'h50 && b[2]) || (off == 'h71 && b[2])) clr[0] = 1;
            if ((off == 'h57 && b[4]) || (off == 'h71 && b[3])) clr[1] = 1;
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (chan_irq[c] && !mp[c])                    mf[c] = 1;
        else if ((!chan_irq[c] && mp[c]) || clr[c])  mf[c] = 0;
        mp[c] = chan_irq[c];
      end
      if (blk_wr) begin mm[0] = blk_wdata[0]; mm[1] = blk_wdata[1]; end
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] dw);
    case (dw)
      6'h02:   return 32'h0000_8F00;
      6'h0F:   return 32'h0000_0100;
      6'h14:   return 32'h0000_0C00 | (32'(mf[0]) << 2);
      6'h15:   return 32'(mf[1]) << 28;
      6'h1C:   return (32'(mf[0]) << 10) | (32'(mf[1]) << 11) |
                      (32'(mm[0]) << 12) | (32'(mm[1]) << 13);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 irq_out vs model", {31'b0, irq_out}, {31'b0, (mf[0] & !mm[0]) | (mf[1] & !mm[1])});
      chk("R3 read vs model", cfg_rdata, m_read(cfg_raddr));
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    step();
    cfg_wr = 1; cfg_waddr = a; cfg_be = be; cfg_wdata = d;
    step();
    cfg_wr = 0; cfg_be = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    cfg_raddr = a;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
    step();
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'b0, irq_out}, {31'b0, exp});
    step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    step();
    // R1 reset state
    rd_chk("R1 ctrl and legacy0", 6'h14, 32'h0000_0C00);
    rd_chk("R1 combined", 6'h1C, 32'h0);
    irq_chk("R1 irq idle", 1'b0);
    // R2 identity bytes
    rd_chk("R2 prog-if", 6'h02, 32'h0000_8F00);
    rd_chk("R2 int pin", 6'h0F, 32'h0000_0100);
    rd_chk("R2 unowned", 6'h00, 32'h0);
    // R4 R3 channel 0 rise
    chan_irq = 2'b01; step();
    rd_chk("R4 legacy0 set", 6'h14, 32'h0000_0C04);
    rd_chk("R3 combined ch0", 6'h1C, 32'h0000_0400);
    irq_chk("R11 irq ch0", 1'b1);
    chan_irq = 2'b11; step();
    rd_chk("R3 legacy1 set", 6'h15, 32'h1000_0000);
    rd_chk("R3 combined both", 6'h1C, 32'h0000_0C00);
    // R6 clear via legacy 0x50
    wr(6'h14, 4'b0001, 32'h0000_0004);
    rd_chk("R6 combined after 0x50 clear", 6'h1C, 32'h0000_0800);
    // R8 ordinary writes ignored
    wr(6'h15, 4'hF, 32'hEF00_0000);
    wr(6'h1C, 4'hF, 32'hFFFF_F3FF);
    rd_chk("R8 combined unchanged", 6'h1C, 32'h0000_0800);
    // R9 disabled lane ignored
    wr(6'h1C, 4'b1101, 32'hFFFF_FFFF);
    rd_chk("R9 disabled lane", 6'h1C, 32'h0000_0800);
    // R10 block ch1
    blk_wr = 1; blk_wdata = 2'b10; step(); blk_wr = 0;
    irq_chk("R10 blocked ch1", 1'b0);
    rd_chk("R10 block bit read", 6'h1C, 32'h0000_2800);
    blk_wr = 1; blk_wdata = 2'b00; step(); blk_wr = 0;
    irq_chk("R10 unblocked", 1'b1);
    // R7 clear via combined
    wr(6'h1C, 4'b0010, 32'h0000_0800);
    rd_chk("R7 legacy1 cleared", 6'h15, 32'h0);
    irq_chk("R7 irq low", 1'b0);
    // R5 falling edge
    chan_irq = 2'b10; step();
    chan_irq = 2'b11; step();
    rd_chk("R4 re-rise ch0", 6'h14, 32'h0000_0C04);
    chan_irq = 2'b10; step();
    rd_chk("R5 fall clears ch0", 6'h14, 32'h0000_0C00);
    // R12 rise with clear in same cycle
    step();
    chan_irq = 2'b11; cfg_wr = 1; cfg_waddr = 6'h14; cfg_be = 4'b0001; cfg_wdata = 32'h4;
    step(); cfg_wr = 0; cfg_be = '0;
    rd_chk("R12 set wins", 6'h14, 32'h0000_0C04);
    // R6 clear via 0x57
    chan_irq = 2'b01; step();
    chan_irq = 2'b11; step();
    rd_chk("R4 ch1 set again", 6'h1C, 32'h0000_0C00);
    wr(6'h15, 4'b1000, 32'h1000_0000);
    rd_chk("R6 combined after 0x57 clear", 6'h1C, 32'h0000_0400);
    // R9 R8 full dword, control byte untouched
    wr(6'h14, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R9 full dword clear", 6'h14, 32'h0000_0C00);
    // randomized phase, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      step();
      cfg_raddr = 6'(($urandom % 2) ? {2'b01, 4'($urandom % 2 ? 4'h4 : 4'h5)} :
                     (($urandom % 2) ? 6'h1C : 6'(($urandom % 3) * 7 + 2)));
      if ($urandom % 6 == 0) chan_irq[$urandom % 2] ^= 1'b1;
      cfg_wr = ($urandom % 4 == 0);
      case ($urandom % 4)
        0: cfg_waddr = 6'h14; 1: cfg_waddr = 6'h15;
        2: cfg_waddr = 6'h1C; default: cfg_waddr = 6'h02;
      endcase
      cfg_be = 4'($urandom);
      cfg_wdata = $urandom;
      blk_wr = ($urandom % 10 == 0);
      blk_wdata = 2'($urandom);
    end
    step();
    cfg_wr = 0; blk_wr = 0;
    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule